// File: doc/BRIEF.md
# Low-Power Entry and Wake Controller

This block decides, cycle by cycle, whether a processor core stays awake, drops into a low-power state, or leaves it. The core issues a wait-for-interrupt or wait-for-event request, or it signals a return from handler code to thread code. The controller then raises a sleep indicator, plus a deep-sleep indicator when the deep mode is selected. It watches interrupt and event inputs and produces a one-cycle wake pulse when the sleep should end.

A one-bit sticky event flag records events that arrive while the core is not waiting for one. The next wait-for-event request consumes the flag and does not sleep. The three control bits arrive as plain inputs: automatic sleep on return to thread code, deep versus ordinary sleep, and letting newly pending but disabled interrupts count as events. Clock gating, power gating, interrupt priority and register access are handled elsewhere.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset `sleep_o`, `deep_o` and `wake_o` are all 0.
- R2: A wait-for-event request made while the event flag is clear and no event is present in that cycle puts the block to sleep: `sleep_o` is 1 from the next cycle.
- R3: An event (`sev_i`, `ext_evt_i`, or a newly pending enabled interrupt) seen while the block is not waiting for an event sets the event flag. The next wait-for-event request clears the flag and does not sleep, and a second such request then does sleep.
- R4: During a wait-for-event sleep, a pulse on `sev_i` or `ext_evt_i` ends the sleep, and the event flag is clear afterwards, so a later wait-for-event request sleeps again.
- R5: A wait-for-interrupt sleep ends only when an interrupt is both pending and enabled. Events, and pending interrupts that are disabled, leave it asleep. A wait-for-interrupt request made while an enabled interrupt is already pending does not sleep.
- R6: A `thread_ret_i` strobe sleeps (waking as in R5) when `cfg_exit_sleep_i` is 1 and has no effect when it is 0.
- R7: `cfg_deep_i` is sampled when sleep is entered, for every kind of entry. `deep_o` equals that sample for the whole sleep, including the wake cycle.
- R8: With `cfg_pend_evt_i` at 0, a newly pending disabled interrupt neither ends a wait-for-event sleep nor sets the event flag. With it at 1, such an interrupt ends the sleep.
- R9: On wake, `wake_o` is 1 for exactly one cycle with `sleep_o` still 1. `sleep_o` and `deep_o` are 0 on the following cycle.
- R10: When several requests arrive in the same awake cycle, wait-for-interrupt wins over wait-for-event, and wait-for-event wins over the return strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_req_i | input | 1 | Wait-for-interrupt request strobe |
| wfe_req_i | input | 1 | Wait-for-event request strobe |
| sev_i | input | 1 | Send-event pulse from the core |
| ext_evt_i | input | 1 | External event pulse |
| thread_ret_i | input | 1 | Return from handler to thread code |
| irq_pend_i | input | NUM_IRQ | Per-interrupt pending levels |
| irq_en_i | input | NUM_IRQ | Per-interrupt enables |
| cfg_exit_sleep_i | input | 1 | Sleep automatically on thread return |
| cfg_deep_i | input | 1 | 0 ordinary sleep, 1 deep sleep |
| cfg_pend_evt_i | input | 1 | Newly pending disabled interrupts act as events |
| sleep_o | output | 1 | Core is in a low-power state |
| deep_o | output | 1 | The low-power state is deep sleep |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The bench starts with an event that arrives before the wait-for-event request. This separates a block that latches the event from one that only reacts to events during sleep. It repeats the request to show that the flag was consumed and that a real wake clears it. A disabled interrupt is raised with the pend-as-event bit at 0 and then at 1. The block must stay asleep in the first case and wake in the second, and a wait-for-interrupt sleep must ignore it in both cases. The bench also sends a return strobe with sleep-on-exit off and then on, and runs sleeps with each deep-select value. This shows that the mode is captured at entry and not tied to one entry path.

// File: rtl/sleep_wake_pkg.sv
// Shared types for the low-power entry and wake controller.
package sleep_wake_pkg;
    // Power state: awake, asleep waiting for an interrupt, asleep waiting
    // for an event, and the single wake-announce cycle.
    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_WFI  = 2'd1,
        PS_WFE  = 2'd2,
        PS_WAKE = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/swc_pend_detect.sv
// Interrupt pending observer.
// Finds interrupts whose pending bit rose this cycle (enabled or any) and
// reports whether any enabled interrupt is pending at all.
// Assumes pending levels are synchronous to clk.
module swc_pend_detect #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] pend_i,
    input  logic [NUM_IRQ-1:0] en_i,
    output logic               rise_any_o,
    output logic               rise_en_o,
    output logic               lvl_en_o
);
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] rise;

    // Remember last cycle's pending levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_i;
    end

    // Derive per-interrupt rising edges and the summary flags.
    always_comb begin
        rise       = pend_i & ~pend_q;
        rise_any_o = |rise;
        rise_en_o  = |(rise & en_i);
        lvl_en_o   = |(pend_i & en_i);
    end
endmodule

// File: rtl/swc_event_latch.sv
// Sticky one-bit event flag. Clear wins over set in the same cycle.
// Assumes set and clear are single-cycle conditions from the controller.
module swc_event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag until consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (clr_i) flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
    end
endmodule

// File: rtl/swc_power_fsm.sv
// Sleep state machine. Accepts requests only while awake (priority:
// wait-for-interrupt, wait-for-event, thread return), captures the deep
// mode on entry and announces wake for one cycle before returning to run.
// Assumes the exit request is already qualified by the sleep-on-exit bit.
module swc_power_fsm
    import sleep_wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfi_req_i,
    input  logic wfe_req_i,
    input  logic exit_req_i,
    input  logic cfg_deep_i,
    input  logic evt_flag_i,
    input  logic evt_now_i,
    input  logic irq_lvl_i,
    output logic evt_clr_o,
    output logic sleep_o,
    output logic deep_o,
    output logic wake_o
);
    pwr_state_t state_q, state_d;
    logic       deep_q, deep_d;

    // Next-state and event-consume decisions.
    always_comb begin
        state_d   = state_q;
        deep_d    = deep_q;
        evt_clr_o = 1'b0;
        unique case (state_q)
            PS_RUN: begin
                if (wfi_req_i || (!wfe_req_i && exit_req_i)) begin
                    if (!irq_lvl_i) begin
                        state_d = PS_WFI;
                        deep_d  = cfg_deep_i;
                    end
                end else if (wfe_req_i) begin
                    evt_clr_o = 1'b1;
                    if (!(evt_flag_i || evt_now_i)) begin
                        state_d = PS_WFE;
                        deep_d  = cfg_deep_i;
                    end
                end
            end
            PS_WFI: if (irq_lvl_i) state_d = PS_WAKE;
            PS_WFE: begin
                if (evt_now_i) begin
                    state_d   = PS_WAKE;
                    evt_clr_o = 1'b1;
                end
            end
            PS_WAKE: begin
                state_d = PS_RUN;
                deep_d  = 1'b0;
            end
            default: state_d = PS_RUN;
        endcase
    end

    // State and captured mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
            deep_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            deep_q  <= deep_d;
        end
    end

    // Outputs decode straight from registers.
    always_comb begin
        sleep_o = (state_q != PS_RUN);
        deep_o  = deep_q;
        wake_o  = (state_q == PS_WAKE);
    end
endmodule

// File: rtl/sleep_wake_ctrl.sv
// Low-power entry and wake controller top level.
// Combines event sources, the sticky event flag and the sleep state machine.
// Assumes all inputs are synchronous to clk and strobes last one cycle.
module sleep_wake_ctrl #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wfi_req_i,
    input  logic               wfe_req_i,
    input  logic               sev_i,
    input  logic               ext_evt_i,
    input  logic               thread_ret_i,
    input  logic [NUM_IRQ-1:0] irq_pend_i,
    input  logic [NUM_IRQ-1:0] irq_en_i,
    input  logic               cfg_exit_sleep_i,
    input  logic               cfg_deep_i,
    input  logic               cfg_pend_evt_i,
    output logic               sleep_o,
    output logic               deep_o,
    output logic               wake_o
);
    logic rise_any, rise_en, lvl_en;
    logic evt_now, evt_flag, evt_clr, exit_req;

    swc_pend_detect #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (irq_pend_i),
        .en_i       (irq_en_i),
        .rise_any_o (rise_any),
        .rise_en_o  (rise_en),
        .lvl_en_o   (lvl_en)
    );

    // Merge every source that counts as an event this cycle.
    always_comb begin
        evt_now  = sev_i | ext_evt_i | rise_en | (cfg_pend_evt_i & rise_any);
        exit_req = thread_ret_i & cfg_exit_sleep_i;
    end

    swc_event_latch u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_now),
        .clr_i  (evt_clr),
        .flag_o (evt_flag)
    );

    swc_power_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfi_req_i  (wfi_req_i),
        .wfe_req_i  (wfe_req_i),
        .exit_req_i (exit_req),
        .cfg_deep_i (cfg_deep_i),
        .evt_flag_i (evt_flag),
        .evt_now_i  (evt_now),
        .irq_lvl_i  (lvl_en),
        .evt_clr_o  (evt_clr),
        .sleep_o    (sleep_o),
        .deep_o     (deep_o),
        .wake_o     (wake_o)
    );
endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
// Port-level property checker for sleep_wake_ctrl, attached by bind.
module sleep_wake_ctrl_chk #(
    parameter int NUM_IRQ = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wfi_req_i,
    input logic               wfe_req_i,
    input logic               thread_ret_i,
    input logic [NUM_IRQ-1:0] irq_pend_i,
    input logic [NUM_IRQ-1:0] irq_en_i,
    input logic               cfg_exit_sleep_i,
    input logic               sleep_o,
    input logic               deep_o,
    input logic               wake_o
);
    // R9
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    // R9
    wake_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> sleep_o);
    // R9
    wake_then_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> (!sleep_o && !deep_o));
    // R7
    deep_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deep_o |-> sleep_o);
    // R7
    deep_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && !wake_o) |=> (deep_o == $past(deep_o)));
    // R2
    stay_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_o && !wfi_req_i && !wfe_req_i && !(thread_ret_i && cfg_exit_sleep_i))
        |=> !sleep_o);
    // R6
    exit_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_o && thread_ret_i && cfg_exit_sleep_i && !wfe_req_i
         && !(|(irq_pend_i & irq_en_i))) |=> sleep_o);
endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wfi_req_i        (wfi_req_i),
    .wfe_req_i        (wfe_req_i),
    .thread_ret_i     (thread_ret_i),
    .irq_pend_i       (irq_pend_i),
    .irq_en_i         (irq_en_i),
    .cfg_exit_sleep_i (cfg_exit_sleep_i),
    .sleep_o          (sleep_o),
    .deep_o           (deep_o),
    .wake_o           (wake_o)
);

// File: tb/sleep_wake_ctrl_tb.sv
module sleep_wake_ctrl_tb;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi, wfe, sev, ext, ret;
    logic [N-1:0] pend, en;
    logic c_exit, c_deep, c_pevt;
    logic sleep_o, deep_o, wake_o;

    // shadow configuration, applied inside drive at the negedge
    logic [N-1:0] n_en = '0;
    logic n_exit = 1'b0, n_deep = 1'b0, n_pevt = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  s;
        logic  d;
        logic  w;
        string tag;
    } exp_t;
    exp_t exq[$];

    always #10 clk = ~clk;

    sleep_wake_ctrl #(.NUM_IRQ(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wfi_req_i(wfi), .wfe_req_i(wfe),
        .sev_i(sev), .ext_evt_i(ext), .thread_ret_i(ret),
        .irq_pend_i(pend), .irq_en_i(en),
        .cfg_exit_sleep_i(c_exit), .cfg_deep_i(c_deep), .cfg_pend_evt_i(c_pevt),
        .sleep_o(sleep_o), .deep_o(deep_o), .wake_o(wake_o)
    );

    // Driver: applies one cycle of stimulus and queues the outputs expected
    // after the following clock edge.
    task automatic drive(input string tag, input logic a_wfi, input logic a_wfe,
                         input logic a_sev, input logic a_ext, input logic a_ret,
                         input logic [N-1:0] a_pend,
                         input logic es, input logic ed, input logic ew);
        exp_t e;
        @(negedge clk);
        wfi = a_wfi; wfe = a_wfe; sev = a_sev; ext = a_ext; ret = a_ret;
        pend = a_pend; en = n_en;
        c_exit = n_exit; c_deep = n_deep; c_pevt = n_pevt;
        e.s = es; e.d = ed; e.w = ew; e.tag = tag;
        exq.push_back(e);
    endtask

    // Monitor: compares outputs 5 ns after each rising edge.
    always begin
        @(posedge clk);
        #5;
        if (exq.size() != 0) begin
            exp_t e;
            e = exq.pop_front();
            checks++;
            if ({sleep_o, deep_o, wake_o} !== {e.s, e.d, e.w}) begin
                fails++;
                $display("FAIL %s: sleep/deep/wake got %b%b%b expected %b%b%b",
                         e.tag, sleep_o, deep_o, wake_o, e.s, e.d, e.w);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wfi = 0; wfe = 0; sev = 0; ext = 0; ret = 0; pend = '0; en = '0;
        c_exit = 0; c_deep = 0; c_pevt = 0;
        repeat (3) @(posedge clk);
        #5;
        // R1 reset state
        checks++;
        if ({sleep_o, deep_o, wake_o} !== 3'b000) begin
            fails++;
            $display("FAIL R1: outputs got %b%b%b expected 000", sleep_o, deep_o, wake_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R3 early event, then R2/R4 wait-for-event behaviour
        drive("R1 idle",          0,0,0,0,0, 8'h00, 0,0,0);
        drive("R3 sev early",     0,0,1,0,0, 8'h00, 0,0,0);
        drive("R3 wfe consumes",  0,1,0,0,0, 8'h00, 0,0,0);
        drive("R2 wfe sleeps",    0,1,0,0,0, 8'h00, 1,0,0);
        drive("R2 asleep",        0,0,0,0,0, 8'h00, 1,0,0);
        drive("R4 ext wakes",     0,0,0,1,0, 8'h00, 1,0,1);
        drive("R9 awake",         0,0,0,0,0, 8'h00, 0,0,0);
        drive("R4 flag cleared",  0,1,0,0,0, 8'h00, 1,0,0);
        drive("R4 sev wakes",     0,0,1,0,0, 8'h00, 1,0,1);
        drive("R9 awake",         0,0,0,0,0, 8'h00, 0,0,0);

        // R5/R7 wait-for-interrupt, deep mode
        n_en = 8'h01; n_deep = 1'b1;
        drive("R7 wfi deep",      1,0,0,0,0, 8'h00, 1,1,0);
        drive("R5 sev ignored",   0,0,1,0,0, 8'h00, 1,1,0);
        drive("R5 irq wakes",     0,0,0,0,0, 8'h01, 1,1,1);
        drive("R9 awake",         0,0,0,0,0, 8'h01, 0,0,0);
        drive("R5 already pend",  1,0,0,0,0, 8'h01, 0,0,0);
        drive("R3 flag from sev", 0,1,0,0,0, 8'h01, 0,0,0);
        drive("R7 wfe deep",      0,1,0,0,0, 8'h01, 1,1,0);
        drive("R4 sev wakes",     0,0,1,0,0, 8'h01, 1,1,1);
        drive("R9 awake",         0,0,0,0,0, 8'h00, 0,0,0);

        // R6 sleep-on-exit
        n_deep = 1'b0;
        drive("R6 exit bit off",  0,0,0,0,1, 8'h00, 0,0,0);
        n_exit = 1'b1;
        drive("R6 exit sleeps",   0,0,0,0,1, 8'h00, 1,0,0);
        drive("R6 asleep",        0,0,0,0,0, 8'h00, 1,0,0);
        drive("R6 irq wakes",     0,0,0,0,0, 8'h01, 1,0,1);
        drive("R9 awake",         0,0,0,0,0, 8'h01, 0,0,0);
        drive("R3 irq set flag",  0,1,0,0,0, 8'h01, 0,0,0);
        drive("R9 idle",          0,0,0,0,0, 8'h00, 0,0,0);
        n_deep = 1'b1;
        drive("R7 exit deep",     0,0,0,0,1, 8'h00, 1,1,0);
        drive("R6 irq wakes",     0,0,0,0,0, 8'h01, 1,1,1);
        drive("R9 awake",         0,0,0,0,0, 8'h01, 0,0,0);
        drive("R3 irq set flag",  0,1,0,0,0, 8'h01, 0,0,0);
        drive("R9 idle",          0,0,0,0,0, 8'h00, 0,0,0);

        // R10 priority: wfi beats wfe (flag clear, no irq) -> wfi sleep
        n_exit = 1'b0; n_deep = 1'b0;
        drive("R10 wfi over wfe", 1,1,0,0,0, 8'h00, 1,0,0);
        drive("R10 sev no wake",  0,0,1,0,0, 8'h00, 1,0,0);
        drive("R10 irq wakes",    0,0,0,0,0, 8'h01, 1,0,1);
        drive("R9 awake",         0,0,0,0,0, 8'h01, 0,0,0);
        drive("R3 consume flag",  0,1,0,0,0, 8'h01, 0,0,0);
        drive("R9 idle",          0,0,0,0,0, 8'h00, 0,0,0);

        // R8 disabled interrupt: bit 2 not enabled
        n_pevt = 1'b0;
        drive("R8 wfe",           0,1,0,0,0, 8'h00, 1,0,0);
        drive("R8 off no wake",   0,0,0,0,0, 8'h04, 1,0,0);
        drive("R8 off asleep",    0,0,0,0,0, 8'h04, 1,0,0);
        drive("R4 sev wakes",     0,0,1,0,0, 8'h04, 1,0,1);
        drive("R9 awake",         0,0,0,0,0, 8'h00, 0,0,0);
        drive("R8 flag not set",  0,1,0,0,0, 8'h00, 1,0,0);
        drive("R4 ext wakes",     0,0,0,1,0, 8'h00, 1,0,1);
        drive("R9 awake",         0,0,0,0,0, 8'h00, 0,0,0);
        n_pevt = 1'b1;
        drive("R8 wfe",           0,1,0,0,0, 8'h00, 1,0,0);
        drive("R8 on wakes",      0,0,0,0,0, 8'h04, 1,0,1);
        drive("R9 awake",         0,0,0,0,0, 8'h04, 0,0,0);
        drive("R9 idle",          0,0,0,0,0, 8'h00, 0,0,0);
        drive("R5 wfi",           1,0,0,0,0, 8'h00, 1,0,0);
        drive("R5 disabled held", 0,0,0,0,0, 8'h04, 1,0,0);
        drive("R5 enabled wakes", 0,0,0,0,0, 8'h05, 1,0,1);
        drive("R9 awake",         0,0,0,0,0, 8'h05, 0,0,0);

        @(negedge clk);
        wfi = 0; wfe = 0; sev = 0; ext = 0; ret = 0;
        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule